// File: doc/BRIEF.md
# Time-Sliced Shared Memory Sequencer

This block lets several processor cores, plus one or more non-CPU masters such as a display fetcher, share a single memory. It runs on the fast memory clock and hands out memory cycles in a fixed circular order. Each core has a clock-enable output. The enable is high only in the one memory cycle that the core owns, so the core moves forward by exactly one bus cycle per turn and stays frozen between turns. Only the memory is shared. Each core keeps its own registers and program counter.

The owner's address, write data and write strobe are steered onto the memory port. Read data goes back only to the owner. It is captured in that master's own holding register when the slot ends. A core that switches to its private full-speed mode drops its shared request and leaves the rotation. A master that is not in the rotation is skipped within the same cycle, so no memory cycle is wasted on it.

The extra masters get read data as a one-cycle `xm_rvalid` pulse. This interface has no ready signal. Slot timing is fixed and cannot be stalled, so the receiver must accept the data in the cycle the pulse is high.

Top module: `tsm_sequencer`

## Requirements
- R1: After reset the rotation starts at master 0. Slots go in ascending index order and wrap around. Cores are indices 0..NUM_CORES-1 and extra masters follow them.
- R2: In any cycle at most one master holds a grant. `mem_en` is high exactly when some master holds one.
- R3: `core_ce[i]` is high only in the cycle that core i owns. The other core enables are low in that cycle.
- R4: The owner of a cycle is the first member found, counting up from the rotation pointer and wrapping. Non-members are skipped in the same cycle. `mem_en` is never low while at least one master is a member.
- R5: `mem_addr`, `mem_wdata` and `mem_we` carry the current owner's address, data and write strobe. `mem_we` is never high without `mem_en`.
- R6: At the end of a read slot (`mem_we` low), `mem_rdata` is stored in the owner's holding register. That register stays unchanged until the owner's next read slot, and a write slot leaves it unchanged.
- R7: An extra master that owns a read slot sees `xm_rvalid` high for one cycle in the next cycle. `xm_rdata` then carries the word read.
- R8: A request input is registered into membership and takes effect one cycle later. `*_connected` shows membership, and a master that is not connected is never granted.
- R9: While `rst` is high, the rotation pointer is set to 0 and membership is cleared. No enable is high during reset or in the first cycle after it.
- R10: With no members, `mem_en`, `mem_we` and every enable stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| core_shared_req | input | NUM_CORES | Core asks to be in the rotation |
| core_addr | input | NUM_CORES*ADDR_W | Per-core address, core i at slice i |
| core_wdata | input | NUM_CORES*DATA_W | Per-core write data |
| core_we | input | NUM_CORES | Per-core write strobe |
| core_ce | output | NUM_CORES | Per-core clock enable |
| core_connected | output | NUM_CORES | Core is in the rotation |
| core_rdata | output | NUM_CORES*DATA_W | Per-core read holding register |
| xm_req | input | NUM_EXTRA | Extra master asks to be in the rotation |
| xm_addr | input | NUM_EXTRA*ADDR_W | Extra master address |
| xm_wdata | input | NUM_EXTRA*DATA_W | Extra master write data |
| xm_we | input | NUM_EXTRA | Extra master write strobe |
| xm_grant | output | NUM_EXTRA | Extra master owns this cycle |
| xm_connected | output | NUM_EXTRA | Extra master is in the rotation |
| xm_rvalid | output | NUM_EXTRA | Read data valid pulse |
| xm_rdata | output | NUM_EXTRA*DATA_W | Extra master read data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write this cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle |

## Verification
The checker tests the following on every cycle: only one owner at a time, `mem_en` matching the grants, no grant to a disconnected master, no idle memory cycle while any master is a member, quiet enables right after reset, holding registers that stay stable outside their owner's slots, and the read-valid pulse for extra masters. The checker cannot confirm the actual rotation order, the skip pattern as membership changes, or which data arrives where. The bench shows these by comparing against cycle sequences worked out by hand and against a memory model that holds known contents.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  // Adds two slot indices and wraps the sum into the range 0..m-1.
  function automatic int circ_add(input int a, input int b, input int m);
    int s;
    s = a + b;
    if (s >= m) s = s - m;
    return s;
  endfunction

  // Width of an index over n items, at least 1.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tsm_slot_pick.sv
module tsm_slot_pick
  import tsm_pkg::*;
#(
  parameter int M  = 4,
  parameter int IW = 2
) (
  input  logic [IW-1:0] base,
  input  logic [M-1:0]  member,
  output logic [IW-1:0] owner,
  output logic          found
);

  // Walk from the farthest offset to the nearest one, so the nearest member wins.
  always_comb begin
    owner = '0;
    found = 1'b0;
    for (int off = M - 1; off >= 0; off--) begin
      int idx;
      idx = circ_add(int'(base), off, M);
      if (member[idx]) begin
        owner = IW'(idx);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tsm_bus_mux.sv
module tsm_bus_mux #(
  parameter int M      = 4,
  parameter int IW     = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [IW-1:0]       owner,
  input  logic                found,
  input  logic [M*ADDR_W-1:0] all_addr,
  input  logic [M*DATA_W-1:0] all_wdata,
  input  logic [M-1:0]        all_we,
  output logic [M-1:0]        grant,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata
);

  for (genvar g = 0; g < M; g++) begin : g_grant
    assign grant[g] = found && (owner == IW'(g));
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    for (int i = 0; i < M; i++) begin
      if (grant[i]) begin
        mem_addr  = all_addr[i*ADDR_W +: ADDR_W];
        mem_wdata = all_wdata[i*DATA_W +: DATA_W];
        mem_we    = all_we[i];
      end
    end
  end

  assign mem_en = found;

endmodule

// File: rtl/tsm_read_hold.sv
module tsm_read_hold #(
  parameter int M      = 4,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [M-1:0]        grant,
  input  logic                mem_we,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [M*DATA_W-1:0] hold_flat,
  output logic [M-1:0]        rvalid
);

  for (genvar g = 0; g < M; g++) begin : g_hold
    logic [DATA_W-1:0] hold_q;
    logic              rv_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q <= '0;
        rv_q   <= 1'b0;
      end else begin
        rv_q <= grant[g] && !mem_we;
        if (grant[g] && !mem_we) hold_q <= mem_rdata;
      end
    end
    assign hold_flat[g*DATA_W +: DATA_W] = hold_q;
    assign rvalid[g] = rv_q;
  end

endmodule

// File: rtl/tsm_sequencer.sv
module tsm_sequencer
  import tsm_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int NUM_EXTRA = 1,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CORES-1:0]          core_shared_req,
  input  logic [NUM_CORES*ADDR_W-1:0]   core_addr,
  input  logic [NUM_CORES*DATA_W-1:0]   core_wdata,
  input  logic [NUM_CORES-1:0]          core_we,
  output logic [NUM_CORES-1:0]          core_ce,
  output logic [NUM_CORES-1:0]          core_connected,
  output logic [NUM_CORES*DATA_W-1:0]   core_rdata,
  input  logic [NUM_EXTRA-1:0]          xm_req,
  input  logic [NUM_EXTRA*ADDR_W-1:0]   xm_addr,
  input  logic [NUM_EXTRA*DATA_W-1:0]   xm_wdata,
  input  logic [NUM_EXTRA-1:0]          xm_we,
  output logic [NUM_EXTRA-1:0]          xm_grant,
  output logic [NUM_EXTRA-1:0]          xm_connected,
  output logic [NUM_EXTRA-1:0]          xm_rvalid,
  output logic [NUM_EXTRA*DATA_W-1:0]   xm_rdata,
  output logic                          mem_en,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [DATA_W-1:0]             mem_rdata
);

  localparam int M  = NUM_CORES + NUM_EXTRA;
  localparam int IW = idx_width(M);

  logic [M-1:0]        member_q;
  logic [IW-1:0]       ptr_q;
  logic [IW-1:0]       owner;
  logic                found;
  logic [M-1:0]        grant;
  logic [M*DATA_W-1:0] hold_flat;
  logic [M-1:0]        rvalid;

  // Registered membership; a reset empties the rotation.
  always_ff @(posedge clk) begin
    if (rst) member_q <= '0;
    else     member_q <= {xm_req, core_shared_req};
  end

  // The pointer moves to the slot after the owner; with no owner it stays put.
  always_ff @(posedge clk) begin
    if (rst)        ptr_q <= '0;
    else if (found) ptr_q <= IW'(circ_add(int'(owner), 1, M));
  end

  tsm_slot_pick #(.M(M), .IW(IW)) u_pick (
    .base   (ptr_q),
    .member (member_q),
    .owner  (owner),
    .found  (found)
  );

  tsm_bus_mux #(.M(M), .IW(IW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .owner     (owner),
    .found     (found),
    .all_addr  ({xm_addr, core_addr}),
    .all_wdata ({xm_wdata, core_wdata}),
    .all_we    ({xm_we, core_we}),
    .grant     (grant),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  tsm_read_hold #(.M(M), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .grant     (grant),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .hold_flat (hold_flat),
    .rvalid    (rvalid)
  );

  assign core_ce        = grant[NUM_CORES-1:0];
  assign xm_grant       = grant[M-1:NUM_CORES];
  assign core_connected = member_q[NUM_CORES-1:0];
  assign xm_connected   = member_q[M-1:NUM_CORES];
  assign core_rdata     = hold_flat[NUM_CORES*DATA_W-1:0];
  assign xm_rdata       = hold_flat[M*DATA_W-1:NUM_CORES*DATA_W];
  assign xm_rvalid      = rvalid[M-1:NUM_CORES];

endmodule

// File: rtl/tsm_sequencer_chk.sv
module tsm_sequencer_chk #(
  parameter int NUM_CORES = 3,
  parameter int NUM_EXTRA = 1,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CORES-1:0]        core_ce,
  input logic [NUM_CORES-1:0]        core_connected,
  input logic [NUM_CORES*DATA_W-1:0] core_rdata,
  input logic [NUM_EXTRA-1:0]        xm_grant,
  input logic [NUM_EXTRA-1:0]        xm_connected,
  input logic [NUM_EXTRA-1:0]        xm_rvalid,
  input logic                        mem_en,
  input logic                        mem_we
);

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xm_grant, core_ce})); // R2

  AST_EN_MATCHES_GRANT: assert property (@(posedge clk) disable iff (rst)
    mem_en == (|{xm_grant, core_ce})); // R2

  AST_NO_IDLE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (|{xm_connected, core_connected}) |-> mem_en); // R4

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en); // R5

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mem_en); // R9

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    AST_CE_NEEDS_MEMBER: assert property (@(posedge clk) disable iff (rst)
      core_ce[g] |-> core_connected[g]); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      !core_ce[g] |=> $stable(core_rdata[g*DATA_W +: DATA_W])); // R6
  end

  for (genvar g = 0; g < NUM_EXTRA; g++) begin : g_xm
    AST_XM_NEEDS_MEMBER: assert property (@(posedge clk) disable iff (rst)
      xm_grant[g] |-> xm_connected[g]); // R8

    AST_XM_RVALID: assert property (@(posedge clk) disable iff (rst)
      (xm_grant[g] && !mem_we) |=> xm_rvalid[g]); // R7
  end

endmodule

bind tsm_sequencer tsm_sequencer_chk #(
  .NUM_CORES(NUM_CORES), .NUM_EXTRA(NUM_EXTRA), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .core_ce        (core_ce),
  .core_connected (core_connected),
  .core_rdata     (core_rdata),
  .xm_grant       (xm_grant),
  .xm_connected   (xm_connected),
  .xm_rvalid      (xm_rvalid),
  .mem_en         (mem_en),
  .mem_we         (mem_we)
);

// File: tb/tsm_sequencer_bench.sv
module tsm_sequencer_bench;

  localparam int NC = 3;
  localparam int NX = 1;
  localparam int AW = 16;
  localparam int DW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NC-1:0]     core_shared_req = '0;
  logic [NC*AW-1:0]  core_addr = {16'd3, 16'd2, 16'd1};
  logic [NC*DW-1:0]  core_wdata = '0;
  logic [NC-1:0]     core_we = '0;
  logic [NC-1:0]     core_ce;
  logic [NC-1:0]     core_connected;
  logic [NC*DW-1:0]  core_rdata;
  logic [NX-1:0]     xm_req = '0;
  logic [NX*AW-1:0]  xm_addr = 16'd4;
  logic [NX*DW-1:0]  xm_wdata = '0;
  logic [NX-1:0]     xm_we = '0;
  logic [NX-1:0]     xm_grant;
  logic [NX-1:0]     xm_connected;
  logic [NX-1:0]     xm_rvalid;
  logic [NX*DW-1:0]  xm_rdata;
  logic              mem_en;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic [DW-1:0]     mem_rdata;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] mem [16];

  always #2 clk = ~clk;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);
  end
  always @(posedge clk) if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[3:0]];

  tsm_sequencer #(.NUM_CORES(NC), .NUM_EXTRA(NX), .ADDR_W(AW), .DATA_W(DW)) u_tsm_sequencer (
    .clk, .rst, .core_shared_req, .core_addr, .core_wdata, .core_we, .core_ce,
    .core_connected, .core_rdata, .xm_req, .xm_addr, .xm_wdata, .xm_we, .xm_grant,
    .xm_connected, .xm_rvalid, .xm_rdata, .mem_en, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Each row: [7:4] request mask {xm, core2, core1, core0} driven this cycle,
  // [3:0] grant mask expected in the following cycle.
  localparam logic [7:0] TBL [16] = '{
    8'hF1, 8'hF2, 8'hF4, 8'hF8, 8'hF1,
    8'hD4, 8'hD8, 8'hD1, 8'hD4,
    8'h51, 8'h54,
    8'h00, 8'h00,
    8'h22, 8'h22,
    8'hF4
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    chk("R9 reset ce", 32'(core_ce), 32'h0);
    chk("R9 reset connected", 32'({xm_connected, core_connected}), 32'h0);
    chk("R9 reset mem_en", 32'(mem_en), 32'h0);
    rst = 1'b0;
    {xm_req, core_shared_req} = TBL[0][7:4];
    #1;
    chk("R9 first cycle after reset quiet", 32'({xm_grant, core_ce}), 32'h0);

    // R1 R3 R4 R8 R10: rotation walk
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk($sformatf("R1/R3/R4 row %0d grant", k - 1), 32'({xm_grant, core_ce}), 32'(TBL[k-1][3:0]));
      chk($sformatf("R8 row %0d connected", k - 1), 32'({xm_connected, core_connected}),
          32'(TBL[k-1][7:4]));
      if (TBL[k-1][7:4] == 4'h0)
        chk($sformatf("R10 row %0d mem_en idle", k - 1), 32'(mem_en), 32'h0);
      if (k < 16) {xm_req, core_shared_req} = TBL[k][7:4];
    end

    // R6: every core read its own address
    chk("R6 core0 rdata", 32'(core_rdata[7:0]), 32'hA1);
    chk("R6 core1 rdata", 32'(core_rdata[15:8]), 32'hA2);
    chk("R6 core2 rdata", 32'(core_rdata[23:16]), 32'hA3);

    // R7: the extra master owns the next cycle, then gets a valid pulse
    @(negedge clk);
    chk("R7 xm grant", 32'(xm_grant), 32'h1);
    chk("R5 xm address routed", 32'(mem_addr), 32'h4);
    @(negedge clk);
    chk("R7 xm rvalid", 32'(xm_rvalid), 32'h1);
    chk("R7 xm rdata", 32'(xm_rdata), 32'hA4);
    @(negedge clk);
    chk("R7 rvalid one cycle", 32'(xm_rvalid), 32'h0);

    // R5 R6: core0 alone writes address 8
    {xm_req, core_shared_req} = 4'b0001;
    core_we[0] = 1'b1;
    core_wdata[7:0] = 8'h5A;
    core_addr[15:0] = 16'd8;
    @(negedge clk);
    @(negedge clk);
    chk("R4 sole member granted", 32'({xm_grant, core_ce}), 32'h1);
    chk("R5 write strobe", 32'(mem_we), 32'h1);
    chk("R5 write address", 32'(mem_addr), 32'h8);
    chk("R5 write data", 32'(mem_wdata), 32'h5A);
    @(negedge clk);
    chk("R5 memory written", 32'(mem[8]), 32'h5A);
    chk("R6 write leaves holding", 32'(core_rdata[7:0]), 32'hA1);
    core_we[0] = 1'b0;
    @(negedge clk);
    chk("R6 read back", 32'(core_rdata[7:0]), 32'h5A);
    chk("R6 core1 held while absent", 32'(core_rdata[15:8]), 32'hA2);

    // R10: empty rotation
    {xm_req, core_shared_req} = 4'b0000;
    @(negedge clk);
    @(negedge clk);
    chk("R10 no grants", 32'({xm_grant, core_ce}), 32'h0);
    chk("R10 no mem_en", 32'(mem_en), 32'h0);
    chk("R10 no mem_we", 32'(mem_we), 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule